// File: doc/BRIEF.md
# Frame DMA Sequencer with Palette Load

This block generates the memory read traffic of a display controller. When fetching is enabled, a two-bit load mode sets the work. The block may first read the colour palette and then stream frame data, read only the palette, or skip the palette and stream frame data only. Frame data comes from one of two buffers. Each buffer is an address range given by a base and an inclusive last address. In dual mode the two buffers alternate frame by frame. Each frame is started by a strobe from the panel timing logic.

Reads go out as bursts on a valid/ready request port. A request holds its address and length stable until the memory side accepts it with ready. Back-pressure only delays the sequence and never reorders or drops a burst. Events collect in a status register whose bits are cleared by writing ones. Each event class can be enabled onto a single interrupt line.

Top module: `frame_fetch_seq`

## Requirements
- R1: In reset and directly after it, `stat_out` is 0, `irq` is 0 and `req_valid` is 0.
- R2: With `load_mode` 0 (palette then data) or 1 (palette only), a rising `run` starts reading the palette from `pal_base` upward. The palette is 32 bytes (8 words) when `bpp8`=0 and 512 bytes (128 words) when `bpp8`=1. Acceptance of its last burst sets status bit 6 (palette done).
- R3: With `load_mode` 1, no read follows the palette, even when `frame_start` pulses.
- R4: With `load_mode` 2 (data only), no palette is read, and the first read after `frame_start` is at the base of buffer 0.
- R5: The burst length in words is 1, 2, 4, 8 or 16 for `burst_code` 0 to 4, and 16 for codes 5 to 7. Consecutive bursts cover consecutive word addresses.
- R6: The last burst of a range is shortened so that it ends exactly at the inclusive last address. Acceptance of that burst ends the frame, and a buffer-0 frame sets status bit 8.
- R7: With `dual_en`=1, successive frames alternate buffer 0, buffer 1, buffer 0. A buffer-1 frame sets status bit 9 and leaves bit 8 unchanged.
- R8: With `dual_en`=0, every frame reads buffer 0 and status bit 9 never sets.
- R9: A `frame_start` that arrives while a frame is still reading sets status bit 5 (underflow). The running frame continues to its end, and no new frame is started by that strobe.
- R10: A `frame_start` in the same cycle as the last burst's acceptance starts the next frame at once and does not set bit 5.
- R11: A status write clears every bit whose `stat_wr_data` bit is 1 and leaves bits written 0 unchanged. An event in the same cycle as a clear of its bit leaves the bit set.
- R12: `irq` is high when (bit 8 or 9) and `eof_irq_en`, or bit 6 and `pld_irq_en`, or (bit 5 or 2) and `ufl_irq_en`.
- R13: While `req_valid` is high and `req_ready` low, address and length stay stable. Dropping `run` withdraws the request at once and resets the buffer order, so the next frame starts from buffer 0.
- R14: A pulse on `sync_lost` sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Fetch enable; low aborts and returns to idle |
| load_mode | input | 2 | 0 palette+data, 1 palette only, 2 data only, 3 no reads |
| dual_en | input | 1 | Alternate buffer 0 and buffer 1 |
| bpp8 | input | 1 | Selects the 512-byte palette |
| burst_code | input | 3 | Burst length code |
| pal_base | input | AW | Palette word address |
| buf0_base | input | AW | Buffer 0 first word |
| buf0_ceil | input | AW | Buffer 0 last word (inclusive) |
| buf1_base | input | AW | Buffer 1 first word |
| buf1_ceil | input | AW | Buffer 1 last word (inclusive) |
| frame_start | input | 1 | One-cycle frame start strobe |
| sync_lost | input | 1 | One-cycle sync loss event |
| eof_irq_en | input | 1 | End-of-frame interrupt enable |
| pld_irq_en | input | 1 | Palette-done interrupt enable |
| ufl_irq_en | input | 1 | Underflow and sync-loss interrupt enable |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | AW | Burst first word address |
| req_len | output | LOGMAX+1 | Burst length in words |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 10 | Ones clear status bits |
| stat_out | output | 10 | Status: 9 eof1, 8 eof0, 6 palette done, 5 underflow, 2 sync lost |
| irq | output | 1 | Interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the acceptance of a frame's last burst and a software write that clears that frame's end-of-frame bit. The bench starts a short frame and times the status write so that it lands on that acceptance edge. The bit is judged correct if it stays set and a later plain write clears it. The second pair is a frame strobe and the last acceptance: they are made to coincide, and the run is judged on the absence of the underflow bit and on the complete second frame in the request log.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  typedef enum logic [2:0] {S_IDLE, S_PAL, S_WAITF, S_DATA, S_HOLD} ffs_state_e;
  typedef enum logic [1:0] {SRC_PAL, SRC_B0, SRC_B1} ffs_src_e;

  localparam int STAT_W   = 10;
  localparam int BIT_EOF1 = 9;
  localparam int BIT_EOF0 = 8;
  localparam int BIT_PLD  = 6;
  localparam int BIT_UFL  = 5;
  localparam int BIT_SYNC = 2;
  localparam logic [STAT_W-1:0] STAT_MASK = 10'h364;

  localparam logic [1:0] MODE_BOTH = 2'd0;
  localparam logic [1:0] MODE_PAL  = 2'd1;
  localparam logic [1:0] MODE_DATA = 2'd2;
endpackage

// File: rtl/ffs_burst.sv
module ffs_burst #(
  parameter int AW = 16,
  parameter int LOGMAX = 4,
  localparam int LW = LOGMAX + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          kill,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ceil,
  input  logic [2:0]    code,
  input  logic          gate,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  output logic          range_done
);
  logic          active;
  logic [AW-1:0] cur;
  logic [AW-1:0] ceil_r;
  logic [LW-1:0] bw;
  logic [AW:0]   remain;
  logic          is_last;
  logic          accept;

  always_comb begin
    if (int'(code) > LOGMAX) bw = LW'(1) << LOGMAX;
    else                     bw = LW'(1) << code;
  end

  assign remain     = {1'b0, ceil_r} - {1'b0, cur} + (AW+1)'(1);
  assign is_last    = remain <= (AW+1)'(bw);
  assign req_len    = is_last ? remain[LW-1:0] : bw;
  assign req_addr   = cur;
  assign req_valid  = active & gate;
  assign accept     = req_valid & req_ready;
  assign range_done = accept & is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      ceil_r <= '0;
    end else if (kill) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      cur    <= base;
      ceil_r <= ceil;
    end else if (accept) begin
      cur <= cur + AW'(req_len);
      if (is_last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/ffs_ctrl.sv
module ffs_ctrl import ffs_pkg::*; #(
  parameter int AW = 16,
  parameter int PAL_SMALL_W = 8,
  parameter int PAL_LARGE_W = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          frame_start,
  input  logic [1:0]    load_mode,
  input  logic          dual_en,
  input  logic          bpp8,
  input  logic [AW-1:0] pal_base,
  input  logic [AW-1:0] buf0_base,
  input  logic [AW-1:0] buf0_ceil,
  input  logic [AW-1:0] buf1_base,
  input  logic [AW-1:0] buf1_ceil,
  input  logic          range_done,
  output logic          ld,
  output logic          kill,
  output logic [AW-1:0] ld_base,
  output logic [AW-1:0] ld_ceil,
  output logic          evt_pld,
  output logic          evt_ufl,
  output logic          evt_eof0,
  output logic          evt_eof1
);
  ffs_state_e state, state_n;
  logic [1:0] mode_r, mode_n;
  logic       sel, sel_n, nxt;
  ffs_src_e   src;
  logic [AW-1:0] pal_ceil;

  assign pal_ceil = pal_base + (bpp8 ? AW'(PAL_LARGE_W - 1) : AW'(PAL_SMALL_W - 1));
  assign nxt      = dual_en ? ~sel : 1'b0;

  always_comb begin
    state_n  = state;
    mode_n   = mode_r;
    sel_n    = sel;
    ld       = 1'b0;
    kill     = 1'b0;
    src      = SRC_PAL;
    evt_pld  = 1'b0;
    evt_ufl  = 1'b0;
    evt_eof0 = 1'b0;
    evt_eof1 = 1'b0;
    if (!run) begin
      state_n = S_IDLE;
      kill    = 1'b1;
      sel_n   = 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          mode_n = load_mode;
          if (load_mode == MODE_BOTH || load_mode == MODE_PAL) begin
            ld      = 1'b1;
            src     = SRC_PAL;
            state_n = S_PAL;
          end else if (load_mode == MODE_DATA) begin
            state_n = S_WAITF;
          end else begin
            state_n = S_HOLD;
          end
        end
        S_PAL: begin
          if (range_done) begin
            evt_pld = 1'b1;
            state_n = (mode_r == MODE_PAL) ? S_HOLD : S_WAITF;
          end
        end
        S_WAITF: begin
          if (frame_start) begin
            ld      = 1'b1;
            sel_n   = dual_en & sel;
            src     = (dual_en & sel) ? SRC_B1 : SRC_B0;
            state_n = S_DATA;
          end
        end
        S_DATA: begin
          if (range_done) begin
            evt_eof0 = ~sel;
            evt_eof1 = sel;
            sel_n    = nxt;
            if (frame_start) begin
              ld  = 1'b1;
              src = nxt ? SRC_B1 : SRC_B0;
            end else begin
              state_n = S_WAITF;
            end
          end else if (frame_start) begin
            evt_ufl = 1'b1;
          end
        end
        S_HOLD: ;
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (src)
      SRC_B0:  begin ld_base = buf0_base; ld_ceil = buf0_ceil; end
      SRC_B1:  begin ld_base = buf1_base; ld_ceil = buf1_ceil; end
      default: begin ld_base = pal_base;  ld_ceil = pal_ceil;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_r <= MODE_BOTH;
      sel    <= 1'b0;
    end else begin
      state  <= state_n;
      mode_r <= mode_n;
      sel    <= sel_n;
    end
  end
endmodule

// File: rtl/ffs_status.sv
module ffs_status import ffs_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_pld,
  input  logic              evt_ufl,
  input  logic              evt_eof0,
  input  logic              evt_eof1,
  input  logic              evt_sync,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              eof_irq_en,
  input  logic              pld_irq_en,
  input  logic              ufl_irq_en,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic [STAT_W-1:0] set_v;
  logic [STAT_W-1:0] clr_v;

  always_comb begin
    set_v           = '0;
    set_v[BIT_EOF1] = evt_eof1;
    set_v[BIT_EOF0] = evt_eof0;
    set_v[BIT_PLD]  = evt_pld;
    set_v[BIT_UFL]  = evt_ufl;
    set_v[BIT_SYNC] = evt_sync;
  end

  assign clr_v = wr_en ? wr_data : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STAT_MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_v[i] | (q & ~clr_v[i]);
      end
      assign stat[i] = q;
    end else begin : g_none
      assign stat[i] = 1'b0;
    end
  end

  assign irq = (eof_irq_en & (stat[BIT_EOF1] | stat[BIT_EOF0]))
             | (pld_irq_en & stat[BIT_PLD])
             | (ufl_irq_en & (stat[BIT_UFL] | stat[BIT_SYNC]));
endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq import ffs_pkg::*; #(
  parameter int AW = 16,
  parameter int LOGMAX = 4,
  parameter int WORD_BYTES = 4,
  parameter int PAL_SMALL_BYTES = 32,
  parameter int PAL_LARGE_BYTES = 512,
  localparam int LW = LOGMAX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        load_mode,
  input  logic              dual_en,
  input  logic              bpp8,
  input  logic [2:0]        burst_code,
  input  logic [AW-1:0]     pal_base,
  input  logic [AW-1:0]     buf0_base,
  input  logic [AW-1:0]     buf0_ceil,
  input  logic [AW-1:0]     buf1_base,
  input  logic [AW-1:0]     buf1_ceil,
  input  logic              frame_start,
  input  logic              sync_lost,
  input  logic              eof_irq_en,
  input  logic              pld_irq_en,
  input  logic              ufl_irq_en,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [LW-1:0]     req_len,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wr_data,
  output logic [STAT_W-1:0] stat_out,
  output logic              irq
);
  localparam int PAL_SMALL_W = PAL_SMALL_BYTES / WORD_BYTES;
  localparam int PAL_LARGE_W = PAL_LARGE_BYTES / WORD_BYTES;

  logic          ld, kill, range_done;
  logic [AW-1:0] ld_base, ld_ceil;
  logic          evt_pld, evt_ufl, evt_eof0, evt_eof1;

  ffs_ctrl #(.AW(AW), .PAL_SMALL_W(PAL_SMALL_W), .PAL_LARGE_W(PAL_LARGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .frame_start(frame_start),
    .load_mode(load_mode), .dual_en(dual_en), .bpp8(bpp8),
    .pal_base(pal_base), .buf0_base(buf0_base), .buf0_ceil(buf0_ceil),
    .buf1_base(buf1_base), .buf1_ceil(buf1_ceil), .range_done(range_done),
    .ld(ld), .kill(kill), .ld_base(ld_base), .ld_ceil(ld_ceil),
    .evt_pld(evt_pld), .evt_ufl(evt_ufl), .evt_eof0(evt_eof0), .evt_eof1(evt_eof1)
  );

  ffs_burst #(.AW(AW), .LOGMAX(LOGMAX)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(ld), .kill(kill),
    .base(ld_base), .ceil(ld_ceil), .code(burst_code), .gate(run),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .range_done(range_done)
  );

  ffs_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_pld(evt_pld), .evt_ufl(evt_ufl),
    .evt_eof0(evt_eof0), .evt_eof1(evt_eof1), .evt_sync(sync_lost),
    .wr_en(stat_wr_en), .wr_data(stat_wr_data),
    .eof_irq_en(eof_irq_en), .pld_irq_en(pld_irq_en), .ufl_irq_en(ufl_irq_en),
    .stat(stat_out), .irq(irq)
  );
endmodule

// File: rtl/ffs_chk.sv
module ffs_chk #(
  parameter int AW = 16,
  parameter int LOGMAX = 4,
  localparam int LW = LOGMAX + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          frame_start,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [LW-1:0] req_len,
  input logic [2:0]    burst_code,
  input logic [9:0]    stat_out,
  input logic          eof_irq_en,
  input logic          pld_irq_en,
  input logic          ufl_irq_en,
  input logic          irq
);
  int max_len;
  assign max_len = (int'(burst_code) > LOGMAX) ? (1 << LOGMAX) : (1 << burst_code);

  // R13
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!run || (req_valid && $stable(req_addr) && $stable(req_len))));

  // R5
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0 && int'(req_len) <= max_len));

  // R9
  ufl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_out[5]) |-> $past(frame_start));

  // R2
  pld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_out[6]) |-> $past(req_valid && req_ready));

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eof_irq_en && !pld_irq_en && !ufl_irq_en) |-> !irq);
endmodule

bind frame_fetch_seq ffs_chk #(.AW(AW), .LOGMAX(LOGMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .frame_start(frame_start),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .burst_code(burst_code), .stat_out(stat_out),
  .eof_irq_en(eof_irq_en), .pld_irq_en(pld_irq_en), .ufl_irq_en(ufl_irq_en),
  .irq(irq)
);

// File: tb/sim_frame_fetch_seq.sv
`timescale 1ns/100ps
module sim_frame_fetch_seq;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [1:0] load_mode = 2'd0;
  logic dual_en = 1'b0, bpp8 = 1'b0;
  logic [2:0] burst_code = 3'd0;
  logic [AW-1:0] pal_base = '0, buf0_base = '0, buf0_ceil = '0, buf1_base = '0, buf1_ceil = '0;
  logic frame_start = 1'b0, sync_lost = 1'b0;
  logic eof_irq_en = 1'b0, pld_irq_en = 1'b0, ufl_irq_en = 1'b0;
  logic req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [4:0] req_len;
  logic stat_wr_en = 1'b0;
  logic [9:0] stat_wr_data = '0;
  logic [9:0] stat_out;
  logic irq;

  always #2.5 clk = ~clk;

  frame_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .load_mode(load_mode), .dual_en(dual_en),
    .bpp8(bpp8), .burst_code(burst_code), .pal_base(pal_base),
    .buf0_base(buf0_base), .buf0_ceil(buf0_ceil), .buf1_base(buf1_base),
    .buf1_ceil(buf1_ceil), .frame_start(frame_start), .sync_lost(sync_lost),
    .eof_irq_en(eof_irq_en), .pld_irq_en(pld_irq_en), .ufl_irq_en(ufl_irq_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .stat_out(stat_out), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [AW-1:0] log_addr [0:1023];
  logic [4:0]    log_len  [0:1023];
  int nlog = 0;
  int stab_err = 0;
  logic prev_hold = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [4:0] prev_len = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold && run && (!req_valid || req_addr != prev_addr || req_len != prev_len))
        stab_err++;
      if (req_valid && req_ready) begin
        if (nlog < 1024) begin
          log_addr[nlog] = req_addr;
          log_len[nlog]  = req_len;
        end
        nlog++;
      end
      prev_hold = req_valid && !req_ready;
      prev_addr = req_addr;
      prev_len  = req_len;
    end
  end

  bit bp = 1'b0;
  initial begin
    req_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1 req_ready = bp ? ~req_ready : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_fs();
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
  endtask

  task automatic wr_stat(input logic [9:0] d);
    @(posedge clk); #1 stat_wr_en = 1'b1; stat_wr_data = d;
    @(posedge clk); #1 stat_wr_en = 1'b0; stat_wr_data = '0;
  endtask

  task automatic wait_bit(input int b, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (stat_out[b]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic quiesce();
    @(posedge clk); #1 run = 1'b0; frame_start = 1'b0; bp = 1'b0;
    wr_stat(10'h3FF);
    cyc(2);
  endtask

  task automatic cfg(input logic [1:0] m, input logic d, input logic b8, input logic [2:0] c,
                     input int pb, input int b0b, input int b0c, input int b1b, input int b1c);
    @(posedge clk); #1;
    load_mode = m; dual_en = d; bpp8 = b8; burst_code = c;
    pal_base = AW'(pb); buf0_base = AW'(b0b); buf0_ceil = AW'(b0c);
    buf1_base = AW'(b1b); buf1_ceil = AW'(b1c);
  endtask

  task automatic go();
    @(posedge clk); #1 run = 1'b1;
  endtask

  task automatic expect_range(inout int idx, input int base, input int ceil, input int code,
                              input string tag);
    bit ok = 1'b1;
    int act = 0, exp = 0;
    int bw = (code > 4) ? 16 : (1 << code);
    int cur = base;
    while (cur <= ceil) begin
      int l = (ceil - cur + 1 < bw) ? (ceil - cur + 1) : bw;
      if (idx >= nlog || int'(log_addr[idx]) != cur || int'(log_len[idx]) != l) begin
        if (ok) begin
          act = (idx < nlog) ? int'(log_addr[idx]) : -1;
          exp = cur;
        end
        ok = 1'b0;
      end
      idx++;
      cur += l;
    end
    chk(ok, tag, act, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(stat_out == '0, "R1 status in reset", stat_out, 0);
    chk(!req_valid, "R1 no request in reset", req_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(stat_out == '0 && !irq, "R1 status and irq after reset", {irq, stat_out}, 0);
    chk(!req_valid, "R1 no request after reset", req_valid, 0);
  endtask

  task automatic t_mode0();
    bit ok; int m, idx;
    quiesce();
    cfg(2'd0, 1'b0, 1'b0, 3'd2, 'h40, 100, 109, 0, 0);
    m = nlog;
    go();
    wait_bit(6, 200, ok);
    chk(ok, "R2 palette done flag", stat_out, 10'h040);
    pulse_fs();
    wait_bit(8, 200, ok);
    chk(ok, "R6 end of frame 0 flag", stat_out, 10'h140);
    cyc(4);
    chk(nlog - m == 5, "R6 burst count palette+frame", nlog - m, 5);
    idx = m;
    expect_range(idx, 'h40, 'h47, 2, "R2 small palette range");
    expect_range(idx, 100, 109, 2, "R6 shortened last burst");
    chk(!stat_out[9], "R8 no eof1 in single mode", stat_out[9], 0);
  endtask

  task automatic t_pal8();
    bit ok; int m, idx;
    quiesce();
    cfg(2'd1, 1'b0, 1'b1, 3'd4, 'h1000, 'h2000, 'h2007, 0, 0);
    m = nlog;
    go();
    wait_bit(6, 300, ok);
    chk(ok, "R2 large palette done", stat_out, 10'h040);
    pulse_fs();
    cyc(20);
    chk(nlog - m == 8, "R3 no reads after palette only", nlog - m, 8);
    idx = m;
    expect_range(idx, 'h1000, 'h107F, 4, "R2 large palette range");
    chk(!stat_out[8], "R3 no end of frame", stat_out[8], 0);
  endtask

  task automatic t_dual();
    bit ok; int m, idx;
    quiesce();
    cfg(2'd2, 1'b1, 1'b0, 3'd3, 0, 'h200, 'h20F, 'h300, 'h307);
    m = nlog;
    go();
    cyc(6);
    chk(nlog == m, "R4 no palette reads", nlog - m, 0);
    chk(!stat_out[6], "R4 no palette done", stat_out[6], 0);
    pulse_fs();
    wait_bit(8, 200, ok);
    chk(ok, "R7 eof0 first frame", stat_out, 10'h100);
    wr_stat(10'h100);
    pulse_fs();
    wait_bit(9, 200, ok);
    chk(ok, "R7 eof1 second frame", stat_out, 10'h200);
    chk(!stat_out[8], "R7 eof0 untouched by buffer 1", stat_out[8], 0);
    pulse_fs();
    wait_bit(8, 200, ok);
    chk(ok, "R7 eof0 third frame", stat_out, 10'h300);
    cyc(3);
    idx = m;
    expect_range(idx, 'h200, 'h20F, 3, "R4 first read at buffer 0 base");
    expect_range(idx, 'h300, 'h307, 3, "R7 second frame buffer 1");
    expect_range(idx, 'h200, 'h20F, 3, "R7 third frame buffer 0");
  endtask

  task automatic t_single();
    bit ok; int m, idx;
    quiesce();
    cfg(2'd2, 1'b0, 1'b0, 3'd2, 0, 'h500, 'h507, 'h600, 'h607);
    m = nlog;
    go();
    cyc(2);
    pulse_fs();
    wait_bit(8, 200, ok);
    wr_stat(10'h100);
    pulse_fs();
    wait_bit(8, 200, ok);
    chk(ok, "R8 second frame done", stat_out, 10'h100);
    chk(!stat_out[9], "R8 eof1 never set", stat_out[9], 0);
    cyc(3);
    idx = m;
    expect_range(idx, 'h500, 'h507, 2, "R8 frame one buffer 0");
    expect_range(idx, 'h500, 'h507, 2, "R8 frame two buffer 0");
  endtask

  task automatic t_codes();
    int codes [3] = '{0, 1, 7};
    foreach (codes[k]) begin
      bit ok; int m, idx;
      quiesce();
      cfg(2'd2, 1'b0, 1'b0, 3'(codes[k]), 0, 0, 20, 0, 0);
      m = nlog;
      go();
      cyc(2);
      pulse_fs();
      wait_bit(8, 300, ok);
      cyc(2);
      idx = m;
      expect_range(idx, 0, 20, codes[k], "R5 burst length per code");
    end
  endtask

  task automatic t_underflow();
    bit ok; int m, idx;
    quiesce();
    cfg(2'd2, 1'b0, 1'b0, 3'd2, 0, 0, 31, 0, 0);
    m = nlog;
    go();
    cyc(2);
    pulse_fs();
    pulse_fs();
    wait_bit(8, 200, ok);
    chk(stat_out[5], "R9 underflow on early strobe", stat_out[5], 1);
    cyc(6);
    chk(nlog - m == 8, "R9 frame continued, no restart", nlog - m, 8);
    idx = m;
    expect_range(idx, 0, 31, 2, "R9 frame addresses intact");
  endtask

  task automatic t_coincide();
    int m, idx;
    quiesce();
    cfg(2'd2, 1'b0, 1'b0, 3'd2, 0, 0, 7, 0, 0);
    m = nlog;
    go();
    cyc(2);
    pulse_fs();
    pulse_fs();
    cyc(10);
    chk(!stat_out[5], "R10 no underflow on coincident strobe", stat_out[5], 0);
    chk(nlog - m == 4, "R10 next frame started", nlog - m, 4);
    idx = m;
    expect_range(idx, 0, 7, 2, "R10 first frame");
    expect_range(idx, 0, 7, 2, "R10 back-to-back frame");
  endtask

  task automatic t_status();
    quiesce();
    cfg(2'd2, 1'b0, 1'b0, 3'd2, 0, 0, 7, 0, 0);
    @(posedge clk); #1 eof_irq_en = 1'b1; pld_irq_en = 1'b0; ufl_irq_en = 1'b0;
    go();
    cyc(2);
    pulse_fs();
    @(posedge clk); #1 stat_wr_en = 1'b1; stat_wr_data = 10'h100;
    @(posedge clk); #1 stat_wr_en = 1'b0; stat_wr_data = '0;
    @(negedge clk);
    chk(stat_out[8], "R11 set wins over same-cycle clear", stat_out[8], 1);
    chk(irq, "R12 irq from eof", irq, 1);
    wr_stat(10'h000);
    @(negedge clk);
    chk(stat_out[8], "R11 writing zero keeps bit", stat_out[8], 1);
    @(posedge clk); #1 eof_irq_en = 1'b0;
    @(negedge clk);
    chk(!irq, "R12 irq masked", irq, 0);
    wr_stat(10'h100);
    @(negedge clk);
    chk(!stat_out[8], "R11 writing one clears", stat_out[8], 0);
    @(posedge clk); #1 sync_lost = 1'b1;
    @(posedge clk); #1 sync_lost = 1'b0;
    @(negedge clk);
    chk(stat_out[2], "R14 sync lost flag", stat_out[2], 1);
    @(posedge clk); #1 pld_irq_en = 1'b1;
    @(negedge clk);
    chk(!irq, "R12 palette enable ignores sync bit", irq, 0);
    @(posedge clk); #1 ufl_irq_en = 1'b1;
    @(negedge clk);
    chk(irq, "R12 irq from sync lost", irq, 1);
    @(posedge clk); #1 ufl_irq_en = 1'b0; pld_irq_en = 1'b0;
  endtask

  task automatic t_backpressure();
    bit ok; int m, idx, se0;
    quiesce();
    cfg(2'd0, 1'b0, 1'b0, 3'd1, 'h80, 'h900, 'h909, 0, 0);
    se0 = stab_err;
    m = nlog;
    @(posedge clk); #1 bp = 1'b1;
    go();
    wait_bit(6, 400, ok);
    pulse_fs();
    wait_bit(8, 400, ok);
    chk(ok, "R13 frame completes under back-pressure", stat_out, 10'h140);
    cyc(4);
    chk(stab_err == se0, "R13 request stable while stalled", stab_err - se0, 0);
    idx = m;
    expect_range(idx, 'h80, 'h87, 1, "R13 palette under back-pressure");
    expect_range(idx, 'h900, 'h909, 1, "R13 frame under back-pressure");
  endtask

  task automatic t_abort();
    bit ok; int m;
    quiesce();
    cfg(2'd2, 1'b1, 1'b0, 3'd0, 0, 'h100, 'h103, 'h700, 'h73F);
    go();
    cyc(2);
    pulse_fs();
    wait_bit(8, 200, ok);
    pulse_fs();
    cyc(5);
    @(posedge clk); #1 run = 1'b0;
    @(negedge clk);
    chk(!req_valid, "R13 run low withdraws request", req_valid, 0);
    wr_stat(10'h3FF);
    cyc(2);
    m = nlog;
    go();
    cyc(2);
    pulse_fs();
    wait_bit(8, 200, ok);
    chk(ok && nlog > m && log_addr[m] == 16'h100, "R13 restart from buffer 0",
        (nlog > m) ? int'(log_addr[m]) : -1, 'h100);
    chk(!stat_out[9], "R13 aborted buffer 1 frame sets no eof1", stat_out[9], 0);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    t_mode0();
    t_pal8();
    t_dual();
    t_single();
    t_codes();
    t_underflow();
    t_coincide();
    t_status();
    t_backpressure();
    t_abort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule